// File: doc/BRIEF.md
# Shared Memory Ownership Access Controller

This block decides, one request at a time, whether an access to one of a set of shared RAM blocks may proceed. Two processing subsystems reach the shared RAM: a master side and a control side, and each has a CPU port and a DMA port. Every request carries the block index, the access kind (read, write or instruction fetch) and the initiator. In the same cycle the block answers with a grant or a deny, and it drives the RAM write enable only for a granted write.

Each shared block has one owner bit. The owning side may write its block, and its CPU may also fetch from it. The other side may only read. Three per-block protection planes can remove rights from the owning side: one stops DMA writes, one stops CPU writes and one stops CPU fetches. All four planes sit behind a small configuration port. Only writes marked as coming from the master side change the planes. Every plane clears to zero at reset, so the master side owns every block with no protection set. A denied request is reported one cycle later as a single-cycle violation pulse that carries the block index and the initiator.

A request is judged in the cycle its valid is high. The block never applies back-pressure, so there is no ready signal and every valid request gets an answer in that cycle. The configuration port also takes a write every cycle without stalling.

Top module: `shmem_access_guard`

## Requirements
- R1: After reset, every bit of all four configuration planes reads back as zero. Every block is therefore master-owned and has no protection.
- R2: A read (req_kind 0) is granted for any initiator on any block, whatever the owner and protection bits.
- R3: With its protection bits clear, the owning side's CPU may write (req_kind 1) and fetch (req_kind 2), and the owning side's DMA may write. Owner bit 0 means master-owned and owner bit 1 means control-owned. req_init bit 1 selects the side (0 master, 1 control) and bit 0 selects DMA (1) or CPU (0).
- R4: A write or fetch from the side that does not own the block is denied, even when all protection bits of that block are clear.
- R5: A fetch by any DMA port is denied, and the reserved kind value 3 is denied for every initiator.
- R6: For the owning side, a set bit in plane 1 denies its DMA writes, a set bit in plane 2 denies its CPU writes and a set bit in plane 3 denies its CPU fetches. Each bit affects only its own block and its own access.
- R7: A configuration write with cfg_wr_master low leaves every plane unchanged.
- R8: A configuration write from the master side takes effect in the cycle after the write. A request in the same cycle as the write is judged by the old value.
- R9: ram_we is high exactly when a write is granted. It stays low for a denied write.
- R10: One cycle after a deny, viol_valid is high for one cycle and carries the denied block index and initiator. When no request was denied in the previous cycle, viol_valid is low.
- R11: cfg_rd_data returns in the same cycle the plane chosen by cfg_rd_sel: 0 owner, 1 DMA-write-disable, 2 CPU-write-disable, 3 fetch-disable. cfg_wr_sel uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_master | input | 1 | Write comes from the master side |
| cfg_wr_sel | input | 2 | Plane to write |
| cfg_wr_data | input | NBLK | New plane value, one bit per block |
| cfg_rd_sel | input | 2 | Plane to read back |
| cfg_rd_data | output | NBLK | Current value of the selected plane |
| req_valid | input | 1 | Request present this cycle |
| req_blk | input | clog2(NBLK) | Target block index |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_init | input | 2 | Initiator: bit 1 side, bit 0 DMA |
| req_grant | output | 1 | Request allowed |
| req_deny | output | 1 | Request refused |
| ram_we | output | 1 | Write enable toward the RAM |
| viol_valid | output | 1 | Violation pulse for last cycle's deny |
| viol_blk | output | clog2(NBLK) | Block index of the violation |
| viol_init | output | 2 | Initiator of the violation |

## Verification
The configuration write and the access decision can fall in the same cycle. A plane update can then race against a request to the block it changes. The random stimulus issues master-side writes to randomly chosen planes alongside random requests, so many requests meet a flip of their own block's bits in the same cycle. A directed case hands a block to the control side while the control CPU writes to that block. The bench model judges each request by the planes as they stood before the clock edge and applies the write only after that edge, so a grant given or withheld too early is reported as a mismatch.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  localparam int NPLANE = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PL_OWNER = 2'd0,
    PL_DMAWD = 2'd1,
    PL_CPUWD = 2'd2,
    PL_XDIS  = 2'd3
  } plane_e;
endpackage

// File: rtl/shmem_cfg_regs.sv
module shmem_cfg_regs
  import shmem_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_master,
  input  logic [1:0]      wr_sel,
  input  logic [NBLK-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [NBLK-1:0] rd_data,
  output logic [NBLK-1:0] own,
  output logic [NBLK-1:0] dma_wd,
  output logic [NBLK-1:0] cpu_wd,
  output logic [NBLK-1:0] exec_dis
);
  logic [NPLANE-1:0][NBLK-1:0] plane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_q <= '0;
    end else if (wr_en && wr_master) begin
      for (int p = 0; p < NPLANE; p++) begin
        if (wr_sel == p[1:0]) plane_q[p] <= wr_data;
      end
    end
  end

  assign own      = plane_q[PL_OWNER];
  assign dma_wd   = plane_q[PL_DMAWD];
  assign cpu_wd   = plane_q[PL_CPUWD];
  assign exec_dis = plane_q[PL_XDIS];
  assign rd_data  = plane_q[rd_sel];

  // R7
  ctl_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_master) |=> $stable(plane_q));

  // R8
  master_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_master) |=> plane_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/shmem_access_judge.sv
module shmem_access_judge
  import shmem_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic [NBLK-1:0]         own,
  input  logic [NBLK-1:0]         dma_wd,
  input  logic [NBLK-1:0]         cpu_wd,
  input  logic [NBLK-1:0]         exec_dis,
  input  logic                    valid,
  input  logic [$clog2(NBLK)-1:0] blk,
  input  logic [1:0]              kind,
  input  logic [1:0]              init,
  output logic                    grant,
  output logic                    deny,
  output logic                    we
);
  logic is_ctl, is_dma, is_owner, allowed;

  always_comb begin
    is_ctl   = init[1];
    is_dma   = init[0];
    is_owner = (own[blk] == is_ctl);
    unique case (acc_kind_e'(kind))
      ACC_READ:  allowed = 1'b1;
      ACC_WRITE: allowed = is_owner && !(is_dma ? dma_wd[blk] : cpu_wd[blk]);
      ACC_FETCH: allowed = is_owner && !is_dma && !exec_dis[blk];
      default:   allowed = 1'b0;
    endcase
  end

  assign grant = valid && allowed;
  assign deny  = valid && !allowed;
  assign we    = grant && (kind == ACC_WRITE);
endmodule

// File: rtl/shmem_access_guard.sv
module shmem_access_guard
  import shmem_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic                    cfg_wr_master,
  input  logic [1:0]              cfg_wr_sel,
  input  logic [NBLK-1:0]         cfg_wr_data,
  input  logic [1:0]              cfg_rd_sel,
  output logic [NBLK-1:0]         cfg_rd_data,
  input  logic                    req_valid,
  input  logic [$clog2(NBLK)-1:0] req_blk,
  input  logic [1:0]              req_kind,
  input  logic [1:0]              req_init,
  output logic                    req_grant,
  output logic                    req_deny,
  output logic                    ram_we,
  output logic                    viol_valid,
  output logic [$clog2(NBLK)-1:0] viol_blk,
  output logic [1:0]              viol_init
);
  localparam int BW = $clog2(NBLK);

  logic [NBLK-1:0] own, dma_wd, cpu_wd, exec_dis;

  shmem_cfg_regs #(.NBLK(NBLK)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_master(cfg_wr_master),
    .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .own(own), .dma_wd(dma_wd), .cpu_wd(cpu_wd), .exec_dis(exec_dis)
  );

  shmem_access_judge #(.NBLK(NBLK)) u_judge (
    .own(own), .dma_wd(dma_wd), .cpu_wd(cpu_wd), .exec_dis(exec_dis),
    .valid(req_valid), .blk(req_blk), .kind(req_kind), .init(req_init),
    .grant(req_grant), .deny(req_deny), .we(ram_we)
  );

  logic          viol_q;
  logic [BW-1:0] vblk_q;
  logic [1:0]    vinit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      vblk_q  <= '0;
      vinit_q <= '0;
    end else begin
      viol_q <= req_deny;
      if (req_deny) begin
        vblk_q  <= req_blk;
        vinit_q <= req_init;
      end
    end
  end

  assign viol_valid = viol_q;
  assign viol_blk   = vblk_q;
  assign viol_init  = vinit_q;

  // R10
  viol_follows_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_deny |=> (viol_valid && viol_blk == $past(req_blk) && viol_init == $past(req_init)));

  // R4
  nonowner_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == ACC_WRITE && own[req_blk] != req_init[1]) |-> !ram_we);

  // R5
  dma_fetch_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_init[0] && req_kind == ACC_FETCH) |-> (req_deny && !req_grant));

  // R2
  read_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == ACC_READ) |-> (req_grant && !ram_we));
endmodule

// File: tb/sim_shmem_access_guard.sv
`timescale 1ns/1ps
module sim_shmem_access_guard;
  localparam int NBLK = 8;
  localparam int BW = $clog2(NBLK);

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, cfg_wr_master = 0;
  logic [1:0] cfg_wr_sel = 0, cfg_rd_sel = 0;
  logic [NBLK-1:0] cfg_wr_data = 0, cfg_rd_data;
  logic req_valid = 0;
  logic [BW-1:0] req_blk = 0, viol_blk;
  logic [1:0] req_kind = 0, req_init = 0, viol_init;
  logic req_grant, req_deny, ram_we, viol_valid;

  always #4 clk = ~clk;

  shmem_access_guard #(.NBLK(NBLK)) u0 (.*);

  int checks = 0, fails = 0;
  logic [NBLK-1:0] m_pl [4];
  logic pv_valid = 0;
  logic [BW-1:0] pv_blk = 0;
  logic [1:0] pv_init = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_allow(input logic [BW-1:0] b, input logic [1:0] k, input logic [1:0] i);
    bit owner = (m_pl[0][b] == i[1]);
    case (k)
      2'd0: return 1;
      2'd1: return owner && !(i[0] ? m_pl[1][b] : m_pl[2][b]);
      2'd2: return owner && !i[0] && !m_pl[3][b];
      default: return 0;
    endcase
  endfunction

  function automatic string m_tag(input logic [BW-1:0] b, input logic [1:0] k, input logic [1:0] i);
    if (k == 2'd0) return "R2";
    if (k == 2'd3 || (k == 2'd2 && i[0])) return "R5";
    if (m_pl[0][b] != i[1]) return "R4";
    if ((k == 2'd1 && (i[0] ? m_pl[1][b] : m_pl[2][b])) || (k == 2'd2 && m_pl[3][b])) return "R6";
    return "R3";
  endfunction

  // one cycle: drive at negedge, check 2 ns later, model update after posedge
  task automatic step(input bit wen, input bit wm, input logic [1:0] ws, input logic [NBLK-1:0] wd,
                      input bit v, input logic [BW-1:0] b, input logic [1:0] k, input logic [1:0] i,
                      input logic [1:0] rs, input string tag_over);
    bit a;
    string tg;
    @(negedge clk);
    cfg_wr_en = wen; cfg_wr_master = wm; cfg_wr_sel = ws; cfg_wr_data = wd; cfg_rd_sel = rs;
    req_valid = v; req_blk = b; req_kind = k; req_init = i;
    #2;
    a = m_allow(b, k, i);
    tg = (tag_over != "") ? tag_over : m_tag(b, k, i);
    chk(req_grant == (v && a) && req_deny == (v && !a), tg, {req_grant, req_deny}, {v && a, v && !a});
    // R9
    chk(ram_we == (v && a && k == 2'd1), "R9", ram_we, v && a && k == 2'd1);
    // R10
    chk(viol_valid == pv_valid && (!pv_valid || (viol_blk == pv_blk && viol_init == pv_init)),
        "R10", {viol_valid, viol_blk, viol_init}, {pv_valid, pv_blk, pv_init});
    // R11
    chk(cfg_rd_data == m_pl[rs], "R11", cfg_rd_data, m_pl[rs]);
    @(posedge clk);
    pv_valid = v && !a; pv_blk = b; pv_init = i;
    if (wen && wm) m_pl[ws] = wd;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    for (int p = 0; p < 4; p++) m_pl[p] = '0;
    #20 rst_n = 1;
    // R1: every plane zero after reset
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); cfg_rd_sel = p[1:0]; #1;
      chk(cfg_rd_data == '0, "R1", cfg_rd_data, 0);
    end
    // R3: master CPU write to master-owned block
    step(0, 0, 0, 0, 1, 3'd5, 2'd1, 2'b00, 0, "R3");
    // R4: control CPU write to master-owned block
    step(0, 0, 0, 0, 1, 3'd5, 2'd1, 2'b10, 0, "R4");
    // R7: control-side write to owner plane ignored
    step(1, 0, 0, 8'hFF, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 3'd2, 2'd2, 2'b10, 0, "R7");
    // R8: hand blocks to control while control CPU writes block 2
    step(1, 1, 0, 8'h04, 1, 3'd2, 2'd1, 2'b10, 0, "R8");
    step(0, 0, 0, 0, 1, 3'd2, 2'd1, 2'b10, 0, "R8");
    // R4: master DMA write to control-owned block
    step(0, 0, 0, 0, 1, 3'd2, 2'd1, 2'b01, 0, "R4");
    // R6: fetch-disable for block 2 stops control CPU fetch
    step(1, 1, 3, 8'h04, 1, 3'd2, 2'd2, 2'b10, 3, "R3");
    step(0, 0, 0, 0, 1, 3'd2, 2'd2, 2'b10, 3, "R6");
    // R6: DMA-write-disable hits DMA but not CPU write
    step(1, 1, 1, 8'h04, 0, 0, 0, 0, 1, "");
    step(0, 0, 0, 0, 1, 3'd2, 2'd1, 2'b11, 1, "R6");
    step(0, 0, 0, 0, 1, 3'd2, 2'd1, 2'b10, 1, "R6");
    // R5: DMA fetch and reserved kind
    step(0, 0, 0, 0, 1, 3'd2, 2'd2, 2'b11, 0, "R5");
    step(0, 0, 0, 0, 1, 3'd0, 2'd3, 2'b00, 0, "R5");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      step(r[1:0] == 2'b00, r[2] | r[3], r[5:4], NBLK'($urandom),
           r[6] | r[7], BW'(r[10:8]), r[12:11], r[14:13], r[16:15], "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule